// File: doc/BRIEF.md
# Ghost-Filtering Key Selector

This block turns one scan of a key matrix into at most one reported key code. A scan result holds up to eight entries. Each entry is either unused or names the row and column of a pressed key. On each scan strobe the block does four things. It rejects the whole set when the pressed keys could be showing a phantom key. It looks for a Fn or Shift key among the entries and uses it to choose the keymap. It translates every key through that keymap. It then reports the first key that was not held in the previous accepted scan.

The three keymaps (plain, shift, fn) each hold 128 codes and are loaded through a synchronous write port. Two things are remembered from one strobe to the next: the last accepted translated set, and the last reported key. The reported key stays on `key_out` and is repeated or cleared according to the rules below. An "idle" indication that arrives with the strobe means no keys are pending, and it wipes this history.

The history controller has two states. CLEAR means there is no stored set. TRACK means a non-empty set is stored. The transitions are:
- RESTART: idle strobe, to CLEAR.
- ACCEPT: accepted set with at least one key, to TRACK.
- EMPTYSET: accepted set with no keys, to CLEAR.
- GHOST: rejected set, state unchanged.

Top module: `ghost_key_selector`

## Requirements
- R1: Each 8-bit entry of `scan_ent` (entry i at bits 8i+7..8i) has valid at bit 7, row at bits 6:3 and column at bits 2:0. Its keymap index is row*8+column. With no modifier present, the plain map is used.
- R2: A write with `map_we` high stores `map_data` at `map_addr` at the clock edge. The map is chosen by `map_sel`: 0 plain, 1 shift, 2 fn. `map_sel`=3 changes no map. The stored code is used by later strobes.
- R3: `key_vld` is high for exactly the one cycle after each `scan_stb` cycle. It is low at all other times.
- R4: A set of 3 or more valid entries is a ghost when some pair of entries shares a column and some pair shares a row. A ghost set makes `key_out` repeat its previous value and leaves the stored set unchanged.
- R5: A set with fewer than 3 valid entries is never treated as a ghost. Neither is a set in which keys share a row but no two share a column.
- R6: The first valid entry in entry order whose plain code is FN_CODE (0xF1) or SHIFT_CODE (0xF2) selects the fn map or the shift map. That map is used for every key of the set.
- R7: Translated codes of 0x00 or 0xFF are dropped from the set. They are never reported and never stored.
- R8: The reported key is the first translated key, in entry order, that is absent from the stored set.
- R9: When no translated key is new, `key_out` keeps its value if that value is in the current set. Otherwise it becomes 0.
- R10: A strobe with `idle` high reports 0 and clears both the stored set and the reported key.
- R11: After reset, `key_out` and `key_vld` are 0, no set is stored, and every keymap entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_stb | input | 1 | One scan result is present this cycle |
| idle | input | 1 | No keys pending, sampled with scan_stb |
| scan_ent | input | 64 | Eight packed scan entries |
| map_we | input | 1 | Keymap write enable |
| map_sel | input | 2 | Keymap select: 0 plain, 1 shift, 2 fn |
| map_addr | input | 7 | Keymap index |
| map_data | input | 8 | Code to write |
| key_out | output | 8 | Reported key code, held between strobes |
| key_vld | output | 1 | Pulses the cycle after each strobe |

## Verification
Modifier selection and ghost rejection act on the same strobe. A set that carries a modifier key may also form a row/column pattern. Three-key sets are driven in which rows are shared but columns are not, so that the modifier's map must take effect while no ghost fires. A true ghost set is then followed by a repeat of the pre-ghost set. The output expected after that repeat is the held key, not a fresh one. This proves that the rejected set never replaced the stored history.

// File: rtl/keysel_pkg.sv
package keysel_pkg;
    typedef enum logic [1:0] {
        MAP_PLAIN = 2'd0,
        MAP_SHIFT = 2'd1,
        MAP_FN    = 2'd2
    } map_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_TRACK = 1'b1
    } hist_st_e;
endpackage

// File: rtl/keymap_bank.sv
module keymap_bank
    import keysel_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int COLS   = 8,
    parameter int CODE_W = 8,
    parameter int N_ENT  = 8,
    localparam int DEPTH = ROWS * COLS,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int NMAP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx    [N_ENT],
    input  map_e              rd_map,
    output logic [CODE_W-1:0] plain_code[N_ENT],
    output logic [CODE_W-1:0] sel_code  [N_ENT]
);
    logic [CODE_W-1:0] bank [NMAP][DEPTH];

    for (genvar m = 0; m < NMAP; m++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int a = 0; a < DEPTH; a++) bank[m][a] <= '0;
            end else if (wr_en && (wr_sel == 2'(m))) begin
                bank[m][wr_addr] <= wr_data;
            end
        end
    end

    for (genvar i = 0; i < N_ENT; i++) begin : g_rd
        always_comb begin
            plain_code[i] = bank[0][rd_idx[i]];
            unique case (rd_map)
                MAP_SHIFT: sel_code[i] = bank[1][rd_idx[i]];
                MAP_FN:    sel_code[i] = bank[2][rd_idx[i]];
                default:   sel_code[i] = bank[0][rd_idx[i]];
            endcase
        end
    end
endmodule

// File: rtl/ghost_detect.sv
module ghost_detect #(
    parameter int N_ENT = 8,
    parameter int ROW_W = 4,
    parameter int COL_W = 3
) (
    input  logic             vld [N_ENT],
    input  logic [ROW_W-1:0] row [N_ENT],
    input  logic [COL_W-1:0] col [N_ENT],
    output logic             ghost
);
    logic [N_ENT-1:0] vld_vec;
    logic             row_pair;
    logic             col_pair;

    always_comb begin
        row_pair = 1'b0;
        col_pair = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            vld_vec[i] = vld[i];
            for (int j = i + 1; j < N_ENT; j++) begin
                if (vld[i] && vld[j]) begin
                    if (row[i] == row[j]) row_pair = 1'b1;
                    if (col[i] == col[j]) col_pair = 1'b1;
                end
            end
        end
        ghost = ($countones(vld_vec) >= 3) && row_pair && col_pair;
    end
endmodule

// File: rtl/new_key_pick.sv
module new_key_pick #(
    parameter int N_ENT  = 8,
    parameter int CODE_W = 8,
    localparam int CNT_W = $clog2(N_ENT + 1)
) (
    input  logic [CODE_W-1:0] cur_code [N_ENT],
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [CODE_W-1:0] prev_code[N_ENT],
    input  logic [CNT_W-1:0]  prev_cnt,
    input  logic [CODE_W-1:0] prev_key,
    output logic              found,
    output logic [CODE_W-1:0] pick,
    output logic              key_present
);
    logic [N_ENT-1:0] seen;

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            seen[i] = 1'b0;
            for (int j = 0; j < N_ENT; j++) begin
                if ((CNT_W'(j) < prev_cnt) && (prev_code[j] == cur_code[i]))
                    seen[i] = 1'b1;
            end
        end
    end

    always_comb begin
        found       = 1'b0;
        pick        = '0;
        key_present = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (CNT_W'(i) < cur_cnt) begin
                if (!found && !seen[i]) begin
                    found = 1'b1;
                    pick  = cur_code[i];
                end
                if (cur_code[i] == prev_key) key_present = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ghost_key_selector.sv
module ghost_key_selector
    import keysel_pkg::*;
#(
    parameter int          N_ENT      = 8,
    parameter int          ROWS       = 16,
    parameter int          COLS       = 8,
    parameter int          CODE_W     = 8,
    parameter logic [7:0]  FN_CODE    = 8'hF1,
    parameter logic [7:0]  SHIFT_CODE = 8'hF2,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int ENT_W = 1 + ROW_W + COL_W,
    localparam int IDX_W = $clog2(ROWS * COLS),
    localparam int CNT_W = $clog2(N_ENT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scan_stb,
    input  logic                   idle,
    input  logic [N_ENT*ENT_W-1:0] scan_ent,
    input  logic                   map_we,
    input  logic [1:0]             map_sel,
    input  logic [IDX_W-1:0]       map_addr,
    input  logic [CODE_W-1:0]      map_data,
    output logic [CODE_W-1:0]      key_out,
    output logic                   key_vld
);
    // entry decode
    logic             e_vld [N_ENT];
    logic [ROW_W-1:0] e_row [N_ENT];
    logic [COL_W-1:0] e_col [N_ENT];
    logic [IDX_W-1:0] e_idx [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_dec
        assign e_vld[i] = scan_ent[i*ENT_W + ENT_W - 1];
        assign e_row[i] = scan_ent[i*ENT_W + COL_W +: ROW_W];
        assign e_col[i] = scan_ent[i*ENT_W +: COL_W];
        assign e_idx[i] = IDX_W'(e_row[i]) * IDX_W'(COLS) + IDX_W'(e_col[i]);
    end

    logic [CODE_W-1:0] plain_code[N_ENT];
    logic [CODE_W-1:0] sel_code  [N_ENT];
    map_e              map_pick;
    logic              ghost_hit;

    keymap_bank #(
        .ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W), .N_ENT(N_ENT)
    ) u_maps (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (map_we),
        .wr_sel    (map_sel),
        .wr_addr   (map_addr),
        .wr_data   (map_data),
        .rd_idx    (e_idx),
        .rd_map    (map_pick),
        .plain_code(plain_code),
        .sel_code  (sel_code)
    );

    ghost_detect #(
        .N_ENT(N_ENT), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_ghost (
        .vld  (e_vld),
        .row  (e_row),
        .col  (e_col),
        .ghost(ghost_hit)
    );

    // modifier search: first valid entry with a modifier plain code
    always_comb begin
        logic hit;
        hit      = 1'b0;
        map_pick = MAP_PLAIN;
        for (int i = 0; i < N_ENT; i++) begin
            if (!hit && e_vld[i]) begin
                if (plain_code[i] == CODE_W'(FN_CODE)) begin
                    hit      = 1'b1;
                    map_pick = MAP_FN;
                end else if (plain_code[i] == CODE_W'(SHIFT_CODE)) begin
                    hit      = 1'b1;
                    map_pick = MAP_SHIFT;
                end
            end
        end
    end

    // translate and compact in entry order
    logic [CODE_W-1:0] cur_code[N_ENT];
    logic [CNT_W-1:0]  cur_cnt;

    always_comb begin
        cur_cnt = '0;
        for (int i = 0; i < N_ENT; i++) cur_code[i] = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (e_vld[i] && (sel_code[i] != '0) && (sel_code[i] != '1)) begin
                cur_code[cur_cnt[$clog2(N_ENT)-1:0]] = sel_code[i];
                cur_cnt = cur_cnt + 1'b1;
            end
        end
    end

    // history registers
    hist_st_e          state_q, state_d;
    logic [CODE_W-1:0] prev_code[N_ENT];
    logic [CNT_W-1:0]  prev_cnt;
    logic [CNT_W-1:0]  eff_cnt;
    logic              pick_found;
    logic [CODE_W-1:0] pick_code;
    logic              key_present;

    assign eff_cnt = (state_q == ST_TRACK) ? prev_cnt : '0;

    new_key_pick #(
        .N_ENT(N_ENT), .CODE_W(CODE_W)
    ) u_pick (
        .cur_code   (cur_code),
        .cur_cnt    (cur_cnt),
        .prev_code  (prev_code),
        .prev_cnt   (eff_cnt),
        .prev_key   (key_out),
        .found      (pick_found),
        .pick       (pick_code),
        .key_present(key_present)
    );

    // next-state: RESTART, GHOST, ACCEPT, EMPTYSET
    always_comb begin
        state_d = state_q;
        if (scan_stb) begin
            unique case (state_q)
                ST_CLEAR, ST_TRACK: begin
                    if (idle)               state_d = ST_CLEAR;
                    else if (ghost_hit)     state_d = state_q;
                    else if (cur_cnt != '0) state_d = ST_TRACK;
                    else                    state_d = ST_CLEAR;
                end
                default: state_d = ST_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // outputs and stored set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_out  <= '0;
            key_vld  <= 1'b0;
            prev_cnt <= '0;
            for (int i = 0; i < N_ENT; i++) prev_code[i] <= '0;
        end else begin
            key_vld <= scan_stb;
            if (scan_stb) begin
                if (idle) begin
                    key_out  <= '0;
                    prev_cnt <= '0;
                end else if (!ghost_hit) begin
                    if (pick_found)       key_out <= pick_code;
                    else if (!key_present) key_out <= '0;
                    prev_cnt <= cur_cnt;
                    for (int i = 0; i < N_ENT; i++) prev_code[i] <= cur_code[i];
                end
            end
        end
    end
endmodule

// File: rtl/ghost_key_selector_chk.sv
module ghost_key_selector_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_stb,
    input logic              idle,
    input logic              ghost_hit,
    input logic [CODE_W-1:0] key_out,
    input logic              key_vld
);
    // R3
    vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stb |=> key_vld);

    // R3
    vld_only_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_stb |=> !key_vld);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_stb && idle) |=> (key_out == '0));

    // R4
    ghost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_stb && !idle && ghost_hit) |=> $stable(key_out));

    // R7
    no_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld |-> (key_out != '1));
endmodule

bind ghost_key_selector ghost_key_selector_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_stb (scan_stb),
    .idle     (idle),
    .ghost_hit(ghost_hit),
    .key_out  (key_out),
    .key_vld  (key_vld)
);

// File: tb/ghost_key_selector_tb.sv
module ghost_key_selector_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_stb = 1'b0;
    logic        idle = 1'b0;
    logic [63:0] scan_ent = '0;
    logic        map_we = 1'b0;
    logic [1:0]  map_sel = '0;
    logic [6:0]  map_addr = '0;
    logic [7:0]  map_data = '0;
    logic [7:0]  key_out;
    logic        key_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ghost_key_selector u_dut (
        .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .idle(idle),
        .scan_ent(scan_ent), .map_we(map_we), .map_sel(map_sel),
        .map_addr(map_addr), .map_data(map_data),
        .key_out(key_out), .key_vld(key_vld)
    );

    function automatic logic [7:0] plain_of(int i);
        if (i == 8)  return 8'hF1;
        if (i == 9)  return 8'hF2;
        if (i == 20) return 8'h00;
        if (i == 21) return 8'hFF;
        return 8'(i + 1);
    endfunction
    function automatic logic [7:0] shift_of(int i);
        if (i == 9) return 8'h00;
        return 8'(i + 8'h80);
    endfunction
    function automatic logic [7:0] fn_of(int i);
        if (i == 8) return 8'h00;
        return 8'(i + 8'h40);
    endfunction

    function automatic logic [7:0] ent(int r, int c);
        return {1'b1, 4'(r), 3'(c)};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_map(logic [1:0] s, int a, logic [7:0] d);
        @(negedge clk);
        map_we = 1'b1; map_sel = s; map_addr = 7'(a); map_data = d;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    // one strobe; checks the pulse, its one-cycle length and the key
    task automatic scan(string tag, logic [63:0] ents, logic idl, logic [7:0] exp);
        @(negedge clk);
        scan_ent = ents; idle = idl; scan_stb = 1'b1;
        @(negedge clk);
        scan_stb = 1'b0; idle = 1'b0; scan_ent = '0;
        check({tag, " R3 vld"}, 8'(key_vld), 8'd1);
        check(tag, key_out, exp);
        @(negedge clk);
        check({tag, " R3 vld drop"}, 8'(key_vld), 8'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 key_out", key_out, 8'h00);
        check("R11 key_vld", 8'(key_vld), 8'd0);
        scan("R11 map cleared", {56'd0, ent(2,3)}, 1'b0, 8'h00);
    endtask

    task automatic t_load();
        for (int i = 0; i < 128; i++) begin
            wr_map(2'd0, i, plain_of(i));
            wr_map(2'd1, i, shift_of(i));
            wr_map(2'd2, i, fn_of(i));
        end
        scan("R2 clear", '0, 1'b1, 8'h00);
    endtask

    task automatic t_newest();
        scan("R1 single", {56'd0, ent(2,3)}, 1'b0, 8'h14);
        scan("R8 new first", {48'd0, ent(2,3), ent(0,5)}, 1'b0, 8'h06);
        scan("R8 order", {40'd0, ent(5,6), ent(4,4), ent(2,3)}, 1'b0, 8'h25);
        scan("R9 hold", {40'd0, ent(5,6), ent(4,4), ent(2,3)}, 1'b0, 8'h25);
        scan("R9 release", {56'd0, ent(2,3)}, 1'b0, 8'h00);
    endtask

    task automatic t_ghost();
        scan("R8 pre ghost", {48'd0, ent(7,7), ent(2,3)}, 1'b0, 8'h40);
        scan("R4 ghost", {40'd0, ent(6,2), ent(3,5), ent(3,2)}, 1'b0, 8'h40);
        scan("R4 set kept", {48'd0, ent(7,7), ent(2,3)}, 1'b0, 8'h40);
        scan("R5 two keys", {48'd0, ent(3,5), ent(3,2)}, 1'b0, 8'h1B);
        scan("R5 row only", {40'd0, ent(3,6), ent(3,5), ent(3,2)}, 1'b0, 8'h1F);
    endtask

    task automatic t_modifier();
        scan("R6 shift", {48'd0, ent(1,1), ent(2,3)}, 1'b0, 8'h93);
        scan("R6 fn", {48'd0, ent(2,3), ent(1,0)}, 1'b0, 8'h53);
        scan("R6 first mod", {40'd0, ent(4,5), ent(1,0), ent(1,1)}, 1'b0, 8'h88);
    endtask

    task automatic t_drop();
        scan("R7 drop", {40'd0, ent(0,1), ent(2,5), ent(2,4)}, 1'b0, 8'h02);
        scan("R7 all dropped", {48'd0, ent(2,5), ent(2,4)}, 1'b0, 8'h00);
    endtask

    task automatic t_idle();
        scan("R10 before", {56'd0, ent(0,1)}, 1'b0, 8'h02);
        scan("R10 idle", {56'd0, ent(0,1)}, 1'b1, 8'h00);
        scan("R10 cleared", {56'd0, ent(0,1)}, 1'b0, 8'h02);
    endtask

    task automatic t_mapwrite();
        wr_map(2'd3, 19, 8'h77);
        scan("R2 idle a", '0, 1'b1, 8'h00);
        scan("R2 sel3 ignored", {56'd0, ent(2,3)}, 1'b0, 8'h14);
        wr_map(2'd0, 19, 8'h55);
        scan("R2 idle b", '0, 1'b1, 8'h00);
        scan("R2 rewrite", {56'd0, ent(2,3)}, 1'b0, 8'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_newest();
        t_ghost();
        t_modifier();
        t_drop();
        t_idle();
        t_mapwrite();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule